// File: doc/BRIEF.md
# Fragmenting Response Frame Builder

This block turns queued read requests into reply frames on a byte-wide transmit stream. A request holds an opcode, a start address and a byte count, and the block takes it from a show-ahead command FIFO. For each request it sends a fixed eight-byte header that echoes the command and describes the fragment. Next come the requested bytes, fetched one at a time from a local memory with a fixed read latency. The frame closes with a two-byte checksum.

A frame carries at most `MAX_PAYLOAD` data bytes. A longer request is split over several frames. Each frame has its own header, giving the offset of its first byte and its own length, and its own checksum. The block takes the next command only after the last frame of the current reply has left. Any opcode other than the read code, and a read of zero bytes, gets a single frame with no payload.

Top module: `resp_frag_builder`

## Requirements
- R1: When the block is idle and `cmd_empty` is low, `cmd_rd` is high for exactly one cycle. The opcode, address and count present in that cycle are the command that is served.
- R2: Every frame begins with eight header bytes: opcode; flags, with bit 0 set on the final fragment and the other bits zero; total requested count (16 bits, high byte first); offset of the fragment's first data byte from the request address (16 bits, high byte first); and the fragment's data length (16 bits, high byte first).
- R3: A command carries data only when its opcode is 0x01 and its count is nonzero. Any other command produces exactly one frame with data length 0, in which the checksum follows the header directly.
- R4: A data byte is the memory byte at (request address + offset), modulo 2^ADDR_W, sent in ascending address order. Exactly one memory read is issued per data byte, and its data is taken `MEM_LAT` cycles after `mem_rd`.
- R5: No frame holds more than `MAX_PAYLOAD` data bytes. Every fragment except the last is full, and the offsets of consecutive fragments advance by the fragment lengths.
- R6: The last two bytes of a frame, high byte first, are the inverted 16-bit ones'-complement sum of the header and data bytes taken as big-endian words. An odd trailing byte is padded with a zero low byte.
- R7: `tx_last` is high only with the second checksum byte of each frame, and never without `tx_valid`.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold and no memory read is issued. No byte is lost or repeated.
- R9: No new command is read until every byte of the previous reply has been accepted.
- R10: During and directly after reset, `tx_valid`, `cmd_rd` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_empty | input | 1 | Command FIFO has no entry |
| cmd_rd | output | 1 | Pop the head command |
| cmd_op | input | 8 | Head command opcode |
| cmd_addr | input | ADDR_W | Head command start address |
| cmd_len | input | CNT_W | Head command byte count |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid MEM_LAT cycles after the strobe |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The bench builds the block with `MAX_PAYLOAD` = 5 and `MEM_LAT` = 3, keeping the 16-bit address and count. The small payload limit makes three-fragment replies, exactly-full fragments and odd-length tails cheap to reach. The three-cycle latency exercises the fetch pipeline beyond a single register. A request near the top of the address space checks wrap-around. Ready patterns that are always high, high two cycles in three, and mostly low cover the stall paths.

// File: rtl/resp_frag_pkg.sv
package resp_frag_pkg;

    localparam logic [7:0] OP_READ   = 8'h01;
    localparam int         HDR_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_FREQ,
        ST_FWAIT,
        ST_DATA,
        ST_SUM_HI,
        ST_SUM_LO
    } bld_state_e;

    // ones'-complement 16-bit addition with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/resp_frag_csum.sv
module resp_frag_csum
    import resp_frag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add_en,
    input  logic [7:0]  byte_in,
    output logic [15:0] csum_o
);

    typedef struct packed {
        logic [15:0] sum;
        logic        odd;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clr) begin
            cs_d.sum = 16'd0;
            cs_d.odd = 1'b0;
        end else if (add_en) begin
            cs_d.sum = oc_add(cs_q.sum, cs_q.odd ? {8'd0, byte_in} : {byte_in, 8'd0});
            cs_d.odd = ~cs_q.odd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign csum_o = ~cs_q.sum;

endmodule

// File: rtl/resp_frag_fetch.sv
module resp_frag_fetch #(
    parameter int ADDR_W  = 16,
    parameter int MEM_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic [7:0]        byte_o
);

    logic [MEM_LAT-1:0] pend_d, pend_q;

    generate
        if (MEM_LAT == 1) begin : g_one
            always_comb pend_d = start;
        end else begin : g_many
            always_comb pend_d = {pend_q[MEM_LAT-2:0], start};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign mem_rd   = start;
    assign mem_addr = addr;
    assign done     = pend_q[MEM_LAT-1];
    assign byte_o   = mem_rdata;

endmodule

// File: rtl/resp_frag_hdr.sv
module resp_frag_hdr #(
    parameter int CNT_W = 16
) (
    input  logic [2:0]       idx,
    input  logic [7:0]       op,
    input  logic             final_frag,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] flen,
    output logic [7:0]       byte_o
);

    logic [15:0] tot16, off16, len16;

    always_comb begin
        tot16 = 16'(total);
        off16 = 16'(offset);
        len16 = 16'(flen);
        case (idx)
            3'd0:    byte_o = op;
            3'd1:    byte_o = {7'd0, final_frag};
            3'd2:    byte_o = tot16[15:8];
            3'd3:    byte_o = tot16[7:0];
            3'd4:    byte_o = off16[15:8];
            3'd5:    byte_o = off16[7:0];
            3'd6:    byte_o = len16[15:8];
            default: byte_o = len16[7:0];
        endcase
    end

endmodule

// File: rtl/resp_frag_builder.sv
module resp_frag_builder
    import resp_frag_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    parameter int MAX_PAYLOAD = 1472,
    parameter int MEM_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_empty,
    output logic              cmd_rd,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_len,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready
);

    localparam logic [CNT_W-1:0] MAX_LEN  = CNT_W'(MAX_PAYLOAD);
    localparam logic [2:0]       HDR_LAST = 3'(HDR_BYTES - 1);

    typedef struct packed {
        bld_state_e        st;
        logic [7:0]        op;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  total;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  offset;
        logic [CNT_W-1:0]  flen;
        logic [CNT_W-1:0]  sent;
        logic [2:0]        idx;
        logic [7:0]        dbyte;
    } bld_t;

    bld_t r_d, r_q;

    logic              cs_clr, cs_add;
    logic [15:0]       csum;
    logic              f_start, f_done;
    logic [7:0]        f_byte;
    logic [7:0]        hdr_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  rem_after;

    function automatic logic [CNT_W-1:0] frag_of(input logic [CNT_W-1:0] r);
        return (r > MAX_LEN) ? MAX_LEN : r;
    endfunction

    assign rd_addr   = r_q.base + ADDR_W'(r_q.offset);
    assign rem_after = r_q.remain - r_q.flen;

    always_comb begin
        r_d      = r_q;
        cmd_rd   = 1'b0;
        f_start  = 1'b0;
        tx_valid = 1'b0;
        tx_data  = 8'd0;
        tx_last  = 1'b0;
        cs_clr   = 1'b0;
        cs_add   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (!cmd_empty) begin
                    cmd_rd     = 1'b1;
                    cs_clr     = 1'b1;
                    r_d.op     = cmd_op;
                    r_d.base   = cmd_addr;
                    r_d.total  = cmd_len;
                    r_d.remain = (cmd_op == OP_READ) ? cmd_len : '0;
                    r_d.flen   = frag_of((cmd_op == OP_READ) ? cmd_len : '0);
                    r_d.offset = '0;
                    r_d.sent   = '0;
                    r_d.idx    = 3'd0;
                    r_d.st     = ST_HDR;
                end
            end
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_data  = hdr_byte;
                if (tx_ready) begin
                    cs_add  = 1'b1;
                    r_d.idx = r_q.idx + 3'd1;
                    if (r_q.idx == HDR_LAST) begin
                        r_d.st = (r_q.flen != '0) ? ST_FREQ : ST_SUM_HI;
                    end
                end
            end
            ST_FREQ: begin
                f_start = 1'b1;
                r_d.st  = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (f_done) begin
                    r_d.dbyte = f_byte;
                    r_d.st    = ST_DATA;
                end
            end
            ST_DATA: begin
                tx_valid = 1'b1;
                tx_data  = r_q.dbyte;
                if (tx_ready) begin
                    cs_add     = 1'b1;
                    r_d.offset = r_q.offset + 1'b1;
                    r_d.sent   = r_q.sent + 1'b1;
                    r_d.st     = (r_q.sent + 1'b1 == r_q.flen) ? ST_SUM_HI : ST_FREQ;
                end
            end
            ST_SUM_HI: begin
                tx_valid = 1'b1;
                tx_data  = csum[15:8];
                if (tx_ready) begin
                    r_d.st = ST_SUM_LO;
                end
            end
            ST_SUM_LO: begin
                tx_valid = 1'b1;
                tx_data  = csum[7:0];
                tx_last  = 1'b1;
                if (tx_ready) begin
                    r_d.remain = rem_after;
                    if (rem_after == '0) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        cs_clr   = 1'b1;
                        r_d.flen = frag_of(rem_after);
                        r_d.sent = '0;
                        r_d.idx  = 3'd0;
                        r_d.st   = ST_HDR;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    resp_frag_hdr #(.CNT_W(CNT_W)) u_hdr (
        .idx        (r_q.idx),
        .op         (r_q.op),
        .final_frag (r_q.remain == r_q.flen),
        .total      (r_q.total),
        .offset     (r_q.offset),
        .flen       (r_q.flen),
        .byte_o     (hdr_byte)
    );

    resp_frag_fetch #(.ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (f_start),
        .addr      (rd_addr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .done      (f_done),
        .byte_o    (f_byte)
    );

    resp_frag_csum u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cs_clr),
        .add_en  (cs_add),
        .byte_in (tx_data),
        .csum_o  (csum)
    );

endmodule

// File: rtl/resp_frag_builder_chk.sv
module resp_frag_builder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_empty,
    input logic       cmd_rd,
    input logic       mem_rd,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_last,
    input logic [7:0] tx_data
);

    p_pop_needs_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> !cmd_empty);

    p_pop_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> !cmd_rd);

    p_last_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_no_fetch_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |-> !mem_rd);

    p_no_pop_while_sending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> !tx_valid);

    p_pop_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> !cmd_rd);

endmodule

bind resp_frag_builder resp_frag_builder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_empty (cmd_empty),
    .cmd_rd    (cmd_rd),
    .mem_rd    (mem_rd),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last),
    .tx_data   (tx_data)
);

// File: tb/resp_frag_builder_tb.sv
`timescale 1ns/1ps
module resp_frag_builder_tb;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int MAXP   = 5;
    localparam int LAT    = 3;

    typedef struct {
        logic [7:0] d;
        logic       last;
        int         kind;
    } exp_t;

    typedef struct {
        logic [7:0] op;
        int         addr;
        int         len;
        int         nb;
    } cmd_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_empty = 1'b1;
    logic              cmd_rd;
    logic [7:0]        cmd_op = 8'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_len = '0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata;
    logic [7:0]        tx_data;
    logic              tx_valid;
    logic              tx_last;
    logic              tx_ready = 1'b0;

    exp_t exp_q[$];
    cmd_t cq[$];
    logic [7:0] mp [LAT];

    int checks = 0, fails = 0;
    int cyc = 0, mode = 0;
    int rd_cnt = 0, exp_reads = 0, pushes = 0, pops = 0, pend = 0;
    bit pop_pending = 0;
    bit stalled = 0;
    logic [7:0] hold_d;
    logic hold_l;

    always #2.5 clk = ~clk;

    resp_frag_builder #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_PAYLOAD(MAXP), .MEM_LAT(LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_empty(cmd_empty), .cmd_rd(cmd_rd),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    function automatic logic [7:0] memf(input int a);
        return 8'((a * 13) + (a >> 8) + 8'h5A);
    endfunction

    // memory model: read data appears LAT cycles after the strobe
    always @(posedge clk) begin
        mp[0] <= mem_rd ? memf(int'(mem_addr)) : 8'h00;
        for (int i = 1; i < LAT; i++) mp[i] <= mp[i-1];
    end
    assign mem_rdata = mp[LAT-1];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic push_exp(input logic [7:0] d, input logic l, input int k);
        exp_t e;
        e.d = d; e.last = l; e.kind = k;
        exp_q.push_back(e);
    endtask

    task automatic add_cmd(input logic [7:0] op, input int addr, input int len);
        int remain, off, fl, nb, s, c, hk;
        logic [7:0] fr[$];
        cmd_t cm;
        remain = (op == 8'h01 && len != 0) ? len : 0;
        hk = (remain == 0) ? 3 : 2;
        off = 0; nb = 0;
        do begin
            fl = (remain > MAXP) ? MAXP : remain;
            fr.delete();
            fr.push_back(op);
            fr.push_back((remain == fl) ? 8'd1 : 8'd0);
            fr.push_back(8'(len >> 8)); fr.push_back(8'(len));
            fr.push_back(8'(off >> 8)); fr.push_back(8'(off));
            fr.push_back(8'(fl >> 8));  fr.push_back(8'(fl));
            for (int i = 0; i < 8; i++) push_exp(fr[i], 1'b0, (i >= 6) ? 5 : hk);
            for (int k = 0; k < fl; k++) begin
                fr.push_back(memf((addr + off + k) & 16'hFFFF));
                push_exp(fr[8+k], 1'b0, 4);
                exp_reads++;
            end
            s = 0;
            for (int i = 0; i < fr.size(); i += 2)
                s += {fr[i], (i + 1 < fr.size()) ? fr[i+1] : 8'h00};
            while ((s >> 16) != 0) s = (s & 16'hFFFF) + (s >> 16);
            c = (~s) & 16'hFFFF;
            push_exp(8'(c >> 8), 1'b0, 6);
            push_exp(8'(c), 1'b1, 6);
            nb += 10 + fl;
            remain -= fl;
            off += fl;
        end while (remain > 0);
        cm.op = op; cm.addr = addr; cm.len = len; cm.nb = nb;
        cq.push_back(cm);
        pend += nb;
        pushes++;
    endtask

    // per-cycle driver and comparison against the reference queues
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (pop_pending) begin
            pend -= cq[0].nb;
            void'(cq.pop_front());
            pop_pending = 0;
        end
        cmd_empty = (cq.size() == 0);
        if (cq.size() > 0) begin
            cmd_op = cq[0].op; cmd_addr = ADDR_W'(cq[0].addr); cmd_len = CNT_W'(cq[0].len);
        end
        case (mode)
            0: tx_ready = 1'b1;
            1: tx_ready = (cyc % 3) != 0;
            default: tx_ready = (cyc % 7) < 2;
        endcase
        #1;
        if (rst_n) begin
            if (stalled && tx_valid) begin
                check(tx_data == hold_d, "R8 hold data", tx_data, hold_d);
                check(tx_last == hold_l, "R8 hold last", tx_last, hold_l);
            end else if (stalled) begin
                check(0, "R8 valid dropped", 0, 1);
            end
            stalled = tx_valid && !tx_ready;
            hold_d = tx_data; hold_l = tx_last;
            if (stalled) check(!mem_rd, "R8 no read in stall", mem_rd, 0);
            if (mem_rd) rd_cnt++;
            if (cmd_rd) begin
                pops++;
                check(!cmd_empty, "R1 pop of empty fifo", cmd_empty, 0);
                check(exp_q.size() == pend, "R9 pop before reply done", exp_q.size(), pend);
                pop_pending = 1;
            end
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected byte", tx_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    case (e.kind)
                        2: check(tx_data == e.d, "R2 header", tx_data, e.d);
                        3: check(tx_data == e.d, "R3 no-data header", tx_data, e.d);
                        4: check(tx_data == e.d, "R4 data", tx_data, e.d);
                        5: check(tx_data == e.d, "R5 fragment length", tx_data, e.d);
                        default: check(tx_data == e.d, "R6 checksum", tx_data, e.d);
                    endcase
                    check(tx_last == e.last, "R7 last flag", tx_last, e.last);
                end
            end
        end
    end

    task automatic drain();
        while (exp_q.size() > 0 || cq.size() > 0) @(posedge clk);
        repeat (10) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(!tx_valid && !cmd_rd && !mem_rd, "R10 in reset", {tx_valid, cmd_rd, mem_rd}, 0);
        @(posedge clk); rst_n <= 1'b1;
        @(negedge clk); #1.5;
        check(!tx_valid && !cmd_rd && !mem_rd, "R10 after reset", {tx_valid, cmd_rd, mem_rd}, 0);

        // mode 0: always ready; multi-fragment, exact fit, no-data opcode
        @(posedge clk);
        add_cmd(8'h01, 16'h0100, 12);
        add_cmd(8'h01, 16'h0200, 5);
        add_cmd(8'h02, 16'h0300, 20);
        drain();

        // mode 1: periodic backpressure; odd lengths, zero count, wrap
        mode = 1;
        add_cmd(8'h01, 16'h0040, 3);
        add_cmd(8'h01, 16'h0050, 0);
        add_cmd(8'h01, 16'hFFFE, 7);
        drain();

        // mode 2: heavy stalls
        mode = 2;
        add_cmd(8'h01, 16'h1234, 11);
        add_cmd(8'h7F, 16'h0000, 0);
        add_cmd(8'h01, 16'h0A00, 1);
        drain();

        check(exp_q.size() == 0, "R9 all frames sent", exp_q.size(), 0);
        check(rd_cnt == exp_reads, "R4 one read per data byte", rd_cnt, exp_reads);
        check(pops == pushes, "R1 commands consumed", pops, pushes);
        check(!tx_valid, "R9 idle at end", tx_valid, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule